// File: doc/BRIEF.md
# Master Clock Source Selector and Prescaler

This block produces two clock-enable pulse trains inside a single fast reference clock domain. Four candidate sources (slow, main, PLL A and PLL B) arrive as single-cycle enable strobes. A configuration register chooses one of them. A power-of-two prescaler thins the chosen strobe train into the processor clock enable. A small ratio divider then takes every first, second, third or fourth processor pulse as the master (bus) clock enable.

Logic downstream qualifies its registers with `cpu_en` or `bus_en` instead of switching real clock nets, so changing the source can never glitch a clock. A write to the configuration register restarts both dividers from a clean phase. A write that carries the reserved prescaler code keeps the old division and raises an error flag. The register can be read back at any time.

Top module: `mck_gen`

## Requirements
- R1: Select field code 0 chooses `src_stb[0]` (slow), 1 chooses `src_stb[1]` (main), 2 chooses `src_stb[2]` (PLL A) and 3 chooses `src_stb[3]` (PLL B).
- R2: With prescaler code n (0 to 6), `cpu_en` is high for exactly one cycle on every 2^n-th strobe of the selected source, counted from the last configuration write. It rises in the cycle right after the clock edge that samples that strobe. With n = 0 every selected strobe gives a pulse.
- R3: With ratio code r (0 to 3), `bus_en` pulses on every (r+1)-th `cpu_en` pulse. With r = 0, `bus_en` equals `cpu_en`.
- R4: `bus_en` is never high unless `cpu_en` is high in the same cycle.
- R5: A write whose prescaler field is 3'b111 leaves the stored prescaler unchanged, still updates the select and ratio fields, and sets `cfg_err`. A write with any other prescaler code stores it and clears `cfg_err`.
- R6: Register layout for `cfg_wdata` and `cfg_rdata`: select in bits 1:0, prescaler in bits 4:2, ratio in bits 9:8. All other bits are ignored on write and read as zero.
- R7: A write clears both divider counters. `cpu_en` and `bus_en` are low in the cycle after the write, and a strobe present in the write cycle is not counted.
- R8: After reset, `cfg_rdata` is zero (slow source, divide by 1, ratio 0), `cfg_err` is low and both enables are low.
- R9: Strobes on the unselected sources have no effect on `cpu_en` or `bus_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_stb | input | 4 | Source enable strobes; bit i is source code i |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| cfg_err | output | 1 | Last write carried the reserved prescaler code |
| cpu_en | output | 1 | Processor clock enable pulse |
| bus_en | output | 1 | Master (bus) clock enable pulse |

## Verification
The bound checker watches the properties that hold cycle by cycle on every cycle:
- bus-enable alignment with the processor enable;
- silence after a write;
- no pulse without a selected strobe;
- a pulse on every strobe at divide-by-1;
- equality of the two enables at ratio 0;
- the readback and error flag after legal and reserved writes.

Only the bench's scenarios can show the counting behaviour. This covers pulse counts over long strobe runs for each select, prescaler and ratio combination, the phase restart in the middle of a count, the discarded strobe in the write cycle, and the immunity to noise on the other sources.

// File: rtl/mck_pkg.sv
package mck_pkg;

    localparam int unsigned MCK_SRC_N     = 4;
    localparam int unsigned MCK_PRES_W    = 3;
    localparam int unsigned MCK_RATIO_W   = 2;
    localparam int unsigned MCK_DATA_W    = 32;
    localparam int unsigned MCK_SEL_LSB   = 0;
    localparam int unsigned MCK_PRES_LSB  = 2;
    localparam int unsigned MCK_RATIO_LSB = 8;

    typedef enum logic [1:0] {
        SRC_SLOW = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_PLLA = 2'd2,
        SRC_PLLB = 2'd3
    } mck_src_e;

endpackage

// File: rtl/mck_cfg_reg.sv
module mck_cfg_reg #(
    parameter int unsigned DATA_W    = mck_pkg::MCK_DATA_W,
    parameter int unsigned SEL_W     = 2,
    parameter int unsigned PRES_W    = mck_pkg::MCK_PRES_W,
    parameter int unsigned RATIO_W   = mck_pkg::MCK_RATIO_W,
    parameter int unsigned SEL_LSB   = mck_pkg::MCK_SEL_LSB,
    parameter int unsigned PRES_LSB  = mck_pkg::MCK_PRES_LSB,
    parameter int unsigned RATIO_LSB = mck_pkg::MCK_RATIO_LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [SEL_W-1:0]   sel_o,
    output logic [PRES_W-1:0]  pres_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               err_o,
    output logic [DATA_W-1:0]  rdata_o
);

    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic [PRES_W-1:0]  pres;
        logic [RATIO_W-1:0] ratio;
        logic               err;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [SEL_W-1:0]   w_sel;
    logic [PRES_W-1:0]  w_pres;
    logic [RATIO_W-1:0] w_ratio;
    logic               w_rsvd;
    logic               unused_wdata;

    assign w_sel        = wdata_i[SEL_LSB +: SEL_W];
    assign w_pres       = wdata_i[PRES_LSB +: PRES_W];
    assign w_ratio      = wdata_i[RATIO_LSB +: RATIO_W];
    assign w_rsvd       = &w_pres;
    assign unused_wdata = ^wdata_i;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            cfg_d.sel   = w_sel;
            cfg_d.ratio = w_ratio;
            if (w_rsvd) begin
                cfg_d.err = 1'b1;
            end else begin
                cfg_d.pres = w_pres;
                cfg_d.err  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        rdata_o[SEL_LSB +: SEL_W]     = cfg_q.sel;
        rdata_o[PRES_LSB +: PRES_W]   = cfg_q.pres;
        rdata_o[RATIO_LSB +: RATIO_W] = cfg_q.ratio;
    end

    assign sel_o   = cfg_q.sel;
    assign pres_o  = cfg_q.pres;
    assign ratio_o = cfg_q.ratio;
    assign err_o   = cfg_q.err;

endmodule

// File: rtl/mck_src_mux.sv
module mck_src_mux #(
    parameter int unsigned SRC_N = mck_pkg::MCK_SRC_N,
    parameter int unsigned SEL_W = $clog2(SRC_N)
) (
    input  logic [SRC_N-1:0] src_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             stb_o
);

    logic [SRC_N-1:0] gated;

    for (genvar g = 0; g < SRC_N; g++) begin : g_leg
        assign gated[g] = src_i[g] && (sel_i == SEL_W'(g));
    end

    assign stb_o = |gated;

endmodule

// File: rtl/mck_prescaler.sv
module mck_prescaler #(
    parameter int unsigned PRES_W = mck_pkg::MCK_PRES_W,
    parameter int unsigned CNT_W  = (1 << PRES_W) - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              stb_i,
    input  logic [PRES_W-1:0] shift_i,
    output logic              hit_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] last;
    logic             at_last;

    always_comb begin
        span    = (CNT_W + 1)'(1) << shift_i;
        last    = CNT_W'(span - (CNT_W + 1)'(1));
        at_last = (pre_q.cnt == last);
        hit_o   = !clr_i && stb_i && at_last;
        pre_d   = pre_q;
        if (clr_i) begin
            pre_d.cnt = '0;
        end else if (stb_i) begin
            pre_d.cnt = at_last ? '0 : pre_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

endmodule

// File: rtl/mck_ratio_div.sv
module mck_ratio_div #(
    parameter int unsigned RATIO_W = mck_pkg::MCK_RATIO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               hit_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               cpu_o,
    output logic               bus_o
);

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic               cpu;
        logic               bus;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d     = div_q;
        div_d.cpu = 1'b0;
        div_d.bus = 1'b0;
        if (clr_i) begin
            div_d.cnt = '0;
        end else if (hit_i) begin
            div_d.cpu = 1'b1;
            if (div_q.cnt == ratio_i) begin
                div_d.bus = 1'b1;
                div_d.cnt = '0;
            end else begin
                div_d.cnt = div_q.cnt + RATIO_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign cpu_o = div_q.cpu;
    assign bus_o = div_q.bus;

endmodule

// File: rtl/mck_gen.sv
module mck_gen #(
    parameter int unsigned SRC_N     = mck_pkg::MCK_SRC_N,
    parameter int unsigned PRES_W    = mck_pkg::MCK_PRES_W,
    parameter int unsigned RATIO_W   = mck_pkg::MCK_RATIO_W,
    parameter int unsigned DATA_W    = mck_pkg::MCK_DATA_W,
    parameter int unsigned SEL_LSB   = mck_pkg::MCK_SEL_LSB,
    parameter int unsigned PRES_LSB  = mck_pkg::MCK_PRES_LSB,
    parameter int unsigned RATIO_LSB = mck_pkg::MCK_RATIO_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_stb,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              cfg_err,
    output logic              cpu_en,
    output logic              bus_en
);

    localparam int unsigned SEL_W = $clog2(SRC_N);
    localparam int unsigned CNT_W = (1 << PRES_W) - 2;

    logic [SEL_W-1:0]   sel;
    logic [PRES_W-1:0]  pres;
    logic [RATIO_W-1:0] ratio;
    logic               sel_stb;
    logic               pre_hit;

    mck_cfg_reg #(
        .DATA_W   (DATA_W),
        .SEL_W    (SEL_W),
        .PRES_W   (PRES_W),
        .RATIO_W  (RATIO_W),
        .SEL_LSB  (SEL_LSB),
        .PRES_LSB (PRES_LSB),
        .RATIO_LSB(RATIO_LSB)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (cfg_wr),
        .wdata_i(cfg_wdata),
        .sel_o  (sel),
        .pres_o (pres),
        .ratio_o(ratio),
        .err_o  (cfg_err),
        .rdata_o(cfg_rdata)
    );

    mck_src_mux #(
        .SRC_N(SRC_N),
        .SEL_W(SEL_W)
    ) u_mux (
        .src_i(src_stb),
        .sel_i(sel),
        .stb_o(sel_stb)
    );

    mck_prescaler #(
        .PRES_W(PRES_W),
        .CNT_W (CNT_W)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cfg_wr),
        .stb_i  (sel_stb),
        .shift_i(pres),
        .hit_o  (pre_hit)
    );

    mck_ratio_div #(
        .RATIO_W(RATIO_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cfg_wr),
        .hit_i  (pre_hit),
        .ratio_i(ratio),
        .cpu_o  (cpu_en),
        .bus_o  (bus_en)
    );

endmodule

// File: rtl/mck_gen_chk.sv
module mck_gen_chk #(
    parameter int unsigned SRC_N     = mck_pkg::MCK_SRC_N,
    parameter int unsigned PRES_W    = mck_pkg::MCK_PRES_W,
    parameter int unsigned RATIO_W   = mck_pkg::MCK_RATIO_W,
    parameter int unsigned DATA_W    = mck_pkg::MCK_DATA_W,
    parameter int unsigned SEL_LSB   = mck_pkg::MCK_SEL_LSB,
    parameter int unsigned PRES_LSB  = mck_pkg::MCK_PRES_LSB,
    parameter int unsigned RATIO_LSB = mck_pkg::MCK_RATIO_LSB
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_N-1:0]  src_stb,
    input logic              cfg_wr,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              cfg_err,
    input logic              cpu_en,
    input logic              bus_en
);

    localparam int unsigned SEL_W = $clog2(SRC_N);

    logic [SEL_W-1:0]   rb_sel;
    logic [PRES_W-1:0]  rb_pres;
    logic [RATIO_W-1:0] rb_ratio;
    logic [PRES_W-1:0]  w_pres;
    logic               cur_stb;

    assign rb_sel   = cfg_rdata[SEL_LSB +: SEL_W];
    assign rb_pres  = cfg_rdata[PRES_LSB +: PRES_W];
    assign rb_ratio = cfg_rdata[RATIO_LSB +: RATIO_W];
    assign w_pres   = cfg_wdata[PRES_LSB +: PRES_W];
    assign cur_stb  = src_stb[rb_sel];

    assert_bus_inside_cpu_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |-> cpu_en);

    assert_quiet_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (!cpu_en && !bus_en));

    assert_no_pulse_without_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && !cur_stb) |=> !cpu_en);

    assert_div1_every_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && cur_stb && rb_pres == '0) |=> cpu_en);

    assert_ratio0_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && rb_ratio == '0) |-> bus_en);

    assert_reserved_keeps_pres_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (&w_pres)) |=> (cfg_err && rb_pres == $past(rb_pres)));

    assert_legal_write_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !(&w_pres)) |=>
            (!cfg_err
             && rb_sel   == $past(cfg_wdata[SEL_LSB +: SEL_W])
             && rb_pres  == $past(cfg_wdata[PRES_LSB +: PRES_W])
             && rb_ratio == $past(cfg_wdata[RATIO_LSB +: RATIO_W])));

    assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ($stable(cfg_rdata) && $stable(cfg_err)));

endmodule

bind mck_gen mck_gen_chk #(
    .SRC_N    (SRC_N),
    .PRES_W   (PRES_W),
    .RATIO_W  (RATIO_W),
    .DATA_W   (DATA_W),
    .SEL_LSB  (SEL_LSB),
    .PRES_LSB (PRES_LSB),
    .RATIO_LSB(RATIO_LSB)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_stb  (src_stb),
    .cfg_wr   (cfg_wr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .cfg_err  (cfg_err),
    .cpu_en   (cpu_en),
    .bus_en   (bus_en)
);

// File: tb/mck_gen_test.sv
module mck_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_stb = '0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_err;
    logic        cpu_en;
    logic        bus_en;

    int n_tests = 0;
    int n_fail  = 0;
    int misalign = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mck_gen uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_stb  (src_stb),
        .cfg_wr   (cfg_wr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .cfg_err  (cfg_err),
        .cpu_en   (cpu_en),
        .bus_en   (bus_en)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [2:0]  pres;
        logic [1:0]  ratio;
        logic [15:0] nstb;
        logic [15:0] exp_cpu;
        logic [15:0] exp_bus;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{sel: 2'd0, pres: 3'd0, ratio: 2'd0, nstb: 16'd5,   exp_cpu: 16'd5, exp_bus: 16'd5},
        '{sel: 2'd1, pres: 3'd1, ratio: 2'd1, nstb: 16'd8,   exp_cpu: 16'd4, exp_bus: 16'd2},
        '{sel: 2'd2, pres: 3'd2, ratio: 2'd2, nstb: 16'd20,  exp_cpu: 16'd5, exp_bus: 16'd1},
        '{sel: 2'd3, pres: 3'd3, ratio: 2'd3, nstb: 16'd33,  exp_cpu: 16'd4, exp_bus: 16'd1},
        '{sel: 2'd1, pres: 3'd6, ratio: 2'd0, nstb: 16'd130, exp_cpu: 16'd2, exp_bus: 16'd2},
        '{sel: 2'd2, pres: 3'd5, ratio: 2'd3, nstb: 16'd64,  exp_cpu: 16'd2, exp_bus: 16'd0},
        '{sel: 2'd3, pres: 3'd0, ratio: 2'd3, nstb: 16'd9,   exp_cpu: 16'd9, exp_bus: 16'd2},
        '{sel: 2'd0, pres: 3'd4, ratio: 2'd1, nstb: 16'd47,  exp_cpu: 16'd2, exp_bus: 16'd1}
    };

    function automatic logic [31:0] cfg_word(input logic [1:0] s, input logic [2:0] p,
                                             input logic [1:0] r);
        return {22'd0, r, 3'd0, p, s};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] w, input logic [3:0] stb);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = w;
        src_stb   = stb;
        @(negedge clk);
        cfg_wr    = 1'b0;
        src_stb   = '0;
    endtask

    task automatic run_stb(input logic [1:0] sel, input int n, input bit noise,
                           output int cpu_cnt, output int bus_cnt);
        logic [3:0] others;
        others  = noise ? ~(4'b1 << sel) : 4'b0;
        cpu_cnt = 0;
        bus_cnt = 0;
        for (int c = 0; c < 2 * n + 2; c++) begin
            @(negedge clk);
            if (cpu_en) cpu_cnt++;
            if (bus_en) bus_cnt++;
            if (bus_en && !cpu_en) misalign++;
            src_stb = others | ((c < 2 * n && c % 2 == 0) ? (4'b1 << sel) : 4'b0);
        end
        src_stb = '0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int cc;
        int bc;
        repeat (3) @(negedge clk);

        // R8: reset state
        chk("R8 rdata in reset", cfg_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 rdata after reset", cfg_rdata, 32'h0);
        chk("R8 err after reset", {31'd0, cfg_err}, 32'd0);
        chk("R8 enables after reset", {30'd0, cpu_en, bus_en}, 32'd0);
        run_stb(2'd0, 3, 1'b0, cc, bc);
        chk("R8 default slow div1 cpu", cc, 3);
        chk("R8 default ratio0 bus", bc, 3);

        // R1 R2 R3 R9: table walk, noise on the unselected sources
        for (int v = 0; v < NVEC; v++) begin
            write_cfg(cfg_word(VECS[v].sel, VECS[v].pres, VECS[v].ratio), 4'b0);
            chk("R6 table readback", cfg_rdata,
                cfg_word(VECS[v].sel, VECS[v].pres, VECS[v].ratio));
            run_stb(VECS[v].sel, int'(VECS[v].nstb), 1'b1, cc, bc);
            chk("R1 R2 R9 cpu pulse count", cc, int'(VECS[v].exp_cpu));
            chk("R3 bus pulse count", bc, int'(VECS[v].exp_bus));
        end
        chk("R4 bus without cpu", misalign, 0);

        // R9: only unselected sources toggle
        write_cfg(cfg_word(2'd1, 3'd0, 2'd0), 4'b0);
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            src_stb = 4'b1101;
        end
        @(negedge clk);
        src_stb = '0;
        chk("R9 cpu idle under noise", {31'd0, cpu_en}, 32'd0);
        run_stb(2'd1, 1, 1'b0, cc, bc);
        chk("R9 first own strobe still pulses", cc, 1);

        // R7: a rewrite restarts the phase mid-count
        write_cfg(cfg_word(2'd1, 3'd2, 2'd0), 4'b0);
        run_stb(2'd1, 3, 1'b0, cc, bc);
        chk("R7 three of four strobes", cc, 0);
        write_cfg(cfg_word(2'd1, 3'd2, 2'd0), 4'b0);
        run_stb(2'd1, 3, 1'b0, cc, bc);
        chk("R7 restarted count", cc, 0);
        run_stb(2'd1, 1, 1'b0, cc, bc);
        chk("R7 fourth after restart", cc, 1);

        // R7: strobe during the write cycle is dropped
        write_cfg(cfg_word(2'd0, 3'd1, 2'd0), 4'b0001);
        chk("R7 quiet after write", {30'd0, cpu_en, bus_en}, 32'd0);
        run_stb(2'd0, 1, 1'b0, cc, bc);
        chk("R7 write-cycle strobe dropped", cc, 0);
        run_stb(2'd0, 1, 1'b0, cc, bc);
        chk("R7 second strobe pulses", cc, 1);

        // R5: reserved prescaler code
        write_cfg(cfg_word(2'd1, 3'd2, 2'd2), 4'b0);
        chk("R5 err clear on legal", {31'd0, cfg_err}, 32'd0);
        write_cfg(cfg_word(2'd2, 3'd7, 2'd1), 4'b0);
        chk("R5 reserved keeps pres", cfg_rdata, cfg_word(2'd2, 3'd2, 2'd1));
        chk("R5 reserved sets err", {31'd0, cfg_err}, 32'd1);
        run_stb(2'd2, 8, 1'b1, cc, bc);
        chk("R5 old pres still divides", cc, 2);
        chk("R5 new ratio applied", bc, 1);
        write_cfg(cfg_word(2'd0, 3'd0, 2'd0), 4'b0);
        chk("R5 legal write clears err", {31'd0, cfg_err}, 32'd0);

        // R6: unused bits ignored and read as zero
        write_cfg(32'hFFFF_FFFB, 4'b0);
        chk("R6 unused bits read zero", cfg_rdata, 32'h0000_031B);
        chk("R6 err after legal full write", {31'd0, cfg_err}, 32'd0);
        run_stb(2'd3, 128, 1'b0, cc, bc);
        chk("R6 decoded div64 cpu", cc, 2);
        chk("R6 decoded ratio3 bus", bc, 0);
        chk("R4 bus without cpu final", misalign, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule